// File: doc/BRIEF.md
# Clock Synthesizer Setup Register and Divider Controller

This block sits behind a serial-bus front end. That front end delivers each three-byte setup message (bytes A, B and C) as a single parallel strobe. The block decodes the messages into the control state of a crystal-locked 8.064 MHz clock synthesizer. This state is an oscillator enable, a 3-bit crystal ratio code, two 6-bit VCO trim words (range and offset), a lock-logic control bit and a 2-bit discriminator field. Every register powers up at a value chosen so that the synthesized clock cannot run fast before software has configured it.

The ratio code selects a pair of dividers. The reference divider counts crystal-clock edges and the feedback divider counts VCO-clock edges. Both counters run in the block's own clock domain. Each one advances on a one-cycle tick input that marks an edge of its source clock. Each counter emits a one-cycle pulse to the external phase detector every N ticks. Both counters are held cleared while the oscillator is disabled, and they restart together whenever a new ratio is written. A sleep request from the system leaves all of this untouched.

Top module: `clksyn_setup_ctrl`

## Requirements
- R1: A strobed message takes effect only when byte B bits 7:6 equal 2'b10 and byte C bits 1:0 equal 2'b00. Any other message leaves every register unchanged.
- R2: A valid message with byte C bit 5, byte B bit 4 and byte B bit 3 all clear is the enable command: byte B bit 0 set turns the oscillator on, and clear turns it off.
- R3: A valid message with byte B bit 4 set and byte C bit 5 clear loads the range trim from byte A bits 5:0.
- R4: A valid message with byte B bit 3 set and byte C bit 5 and byte B bit 4 both clear loads the offset trim from byte A bits 5:0.
- R5: After reset: enable = 1, ratio code = 3'b110, range = 6'h21, offset = 6'h0A, lock control = 0, discriminator = 2'b00.
- R6: A valid message with byte C bit 5 set is the ratio command. It stores byte A bits 2:0 as the ratio code, bit 5 as lock control and bits 7:6 as the discriminator field.
- R7: When several command-select bits are set, the ratio command wins over range, and range wins over offset.
- R8: Ratio code 3'b100 gives reference ÷100 and feedback ÷63. Code 3'b011 gives ÷825 and ÷448. Code 3'b101 gives ÷337 and ÷183. Code 3'b110 gives ÷120 and ÷63.
- R9: A ratio command carrying code 000, 001, 010 or 111 is ignored entirely. The code, lock bit and discriminator field keep their values and the counters do not restart.
- R10: While the oscillator is disabled, both counters stay cleared and neither pulse output asserts. After enable, the first reference pulse appears on the N-th tick.
- R11: The cycle after a ratio write, both counters clear. Each then pulses on its N-th following tick, and keeps pulsing once per N ticks of its own tick input.
- R12: The sleep request has no effect on the enable state, the registers or the divider pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| msg_valid | input | 1 | One-cycle strobe marking a complete setup message |
| msg_a | input | 8 | First message byte (data payload) |
| msg_b | input | 8 | Second message byte (header and select bits) |
| msg_c | input | 8 | Third message byte (trailer and ratio select) |
| sleep_req | input | 1 | System sleep request |
| ref_tick | input | 1 | One-cycle marker of a crystal-clock edge |
| fb_tick | input | 1 | One-cycle marker of a VCO-clock edge |
| osc_en | output | 1 | Oscillator enable |
| ratio_code | output | 3 | Current crystal ratio code |
| range_trim | output | 6 | VCO range trim word |
| offset_trim | output | 6 | VCO offset trim word |
| lock_ctl | output | 1 | Lock-logic control bit |
| disc_ctl | output | 2 | Discriminator programming field |
| ref_pulse | output | 1 | Divided crystal pulse to the phase detector |
| fb_pulse | output | 1 | Divided VCO pulse to the phase detector |

## Verification
The properties take the tick inputs to be single-cycle markers that may arrive on any cycle. They take the message bytes to matter only while the strobe is high. They also assume that the oscillator's enable state can change only through a message, so sleep toggling in the same cycle as a strobe is not covered by the sleep property. The stimulus honours these assumptions. It strobes each message for exactly one cycle, with sleep changes and strobes kept apart, and drives the ticks either on every cycle or on alternate cycles, so that the period of each divider can be counted in block cycles.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;
   localparam int CODE_W  = 3;
   localparam int DIV_W   = 10;
   localparam int MAX_DIV = 825;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_RATIO,
      CMD_RANGE,
      CMD_OFFSET,
      CMD_ENABLE
   } cmd_e;

   function automatic logic code_ok(input logic [CODE_W-1:0] code);
      return (code == 3'b100) || (code == 3'b011) ||
             (code == 3'b101) || (code == 3'b110);
   endfunction

   function automatic logic [DIV_W-1:0] ref_div(input logic [CODE_W-1:0] code);
      case (code)
         3'b100:  return DIV_W'(100);
         3'b011:  return DIV_W'(825);
         3'b101:  return DIV_W'(337);
         default: return DIV_W'(120);
      endcase
   endfunction

   function automatic logic [DIV_W-1:0] fb_div(input logic [CODE_W-1:0] code);
      case (code)
         3'b011:  return DIV_W'(448);
         3'b101:  return DIV_W'(183);
         default: return DIV_W'(63);
      endcase
   endfunction
endpackage

// File: rtl/clksyn_setup_decode.sv
module clksyn_setup_decode
   import clksyn_pkg::*;
#(
   parameter int                TRIM_W     = 6,
   parameter logic [TRIM_W-1:0] RANGE_RST  = 6'h21,
   parameter logic [TRIM_W-1:0] OFFSET_RST = 6'h0A,
   parameter logic [CODE_W-1:0] CODE_RST   = 3'b110,
   parameter logic              EN_RST     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              msg_valid,
   input  logic [7:0]        msg_a,
   input  logic [7:0]        msg_b,
   input  logic [7:0]        msg_c,
   output logic              osc_en,
   output logic [CODE_W-1:0] ratio_code,
   output logic [TRIM_W-1:0] range_trim,
   output logic [TRIM_W-1:0] offset_trim,
   output logic              lock_ctl,
   output logic [1:0]        disc_ctl,
   output logic              ratio_load
);
   if (TRIM_W < 1 || TRIM_W > 6) begin : g_bad_trim
      $error("TRIM_W must lie in 1..6");
   end
   if (!code_ok(CODE_RST)) begin : g_bad_code
      $error("CODE_RST must be a listed ratio code");
   end

   cmd_e cmd;
   logic hdr_ok;
   logic unused_bits;

   assign hdr_ok      = (msg_b[7:6] == 2'b10) && (msg_c[1:0] == 2'b00);
   assign unused_bits = ^{msg_a[4:3], msg_b[5], msg_b[2:1], msg_c[7:6], msg_c[4:2]};

   always_comb begin
      cmd = CMD_NONE;
      if (msg_valid && hdr_ok) begin
         if (msg_c[5])      cmd = CMD_RATIO;
         else if (msg_b[4]) cmd = CMD_RANGE;
         else if (msg_b[3]) cmd = CMD_OFFSET;
         else               cmd = CMD_ENABLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         osc_en      <= EN_RST;
         ratio_code  <= CODE_RST;
         range_trim  <= RANGE_RST;
         offset_trim <= OFFSET_RST;
         lock_ctl    <= 1'b0;
         disc_ctl    <= 2'b00;
         ratio_load  <= 1'b0;
      end else begin
         ratio_load <= 1'b0;
         case (cmd)
            CMD_RATIO: begin
               if (code_ok(msg_a[2:0])) begin
                  ratio_code <= msg_a[2:0];
                  lock_ctl   <= msg_a[5];
                  disc_ctl   <= msg_a[7:6];
                  ratio_load <= 1'b1;
               end
            end
            CMD_RANGE:  range_trim  <= msg_a[TRIM_W-1:0];
            CMD_OFFSET: offset_trim <= msg_a[TRIM_W-1:0];
            CMD_ENABLE: osc_en      <= msg_b[0];
            default: ;
         endcase
      end
   end

   p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !msg_valid |=> ($stable(osc_en) && $stable(ratio_code) && $stable(range_trim) &&
                      $stable(offset_trim) && $stable(lock_ctl) && $stable(disc_ctl)));

   p_bad_code_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && hdr_ok && msg_c[5] && !code_ok(msg_a[2:0]))
         |=> ($stable(ratio_code) && !ratio_load));

   p_code_listed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      code_ok(ratio_code));

   p_ratio_beats_trims_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_c[5]) |=> ($stable(range_trim) && $stable(offset_trim)));
endmodule

// File: rtl/clksyn_tick_div.sv
module clksyn_tick_div #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic [CNT_W-1:0] div_n,
   output logic             pulse
);
   if (CNT_W < 2) begin : g_bad_w
      $error("CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt;
   logic             wrap;

   assign wrap = (cnt >= div_n - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         pulse <= 1'b0;
      end else if (clr) begin
         cnt   <= '0;
         pulse <= 1'b0;
      end else if (tick) begin
         cnt   <= wrap ? '0 : cnt + 1'b1;
         pulse <= wrap;
      end else begin
         pulse <= 1'b0;
      end
   end

   p_clr_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0 && !pulse));

   p_pulse_needs_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> ($past(tick) && !$past(clr)));
endmodule

// File: rtl/clksyn_setup_ctrl.sv
module clksyn_setup_ctrl
   import clksyn_pkg::*;
#(
   parameter int          TRIM_W     = 6,
   parameter int          CNT_W      = DIV_W,
   parameter logic [5:0]  RANGE_RST  = 6'h21,
   parameter logic [5:0]  OFFSET_RST = 6'h0A,
   parameter logic [2:0]  CODE_RST   = 3'b110,
   parameter logic        EN_RST     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              msg_valid,
   input  logic [7:0]        msg_a,
   input  logic [7:0]        msg_b,
   input  logic [7:0]        msg_c,
   input  logic              sleep_req,
   input  logic              ref_tick,
   input  logic              fb_tick,
   output logic              osc_en,
   output logic [2:0]        ratio_code,
   output logic [TRIM_W-1:0] range_trim,
   output logic [TRIM_W-1:0] offset_trim,
   output logic              lock_ctl,
   output logic [1:0]        disc_ctl,
   output logic              ref_pulse,
   output logic              fb_pulse
);
   localparam int N_DIV = 2;

   if (CNT_W < $clog2(MAX_DIV + 1)) begin : g_bad_cnt
      $error("CNT_W too narrow for the largest divider");
   end

   logic                ratio_load;
   logic                div_clr;
   logic [N_DIV-1:0]    tick_v;
   logic [N_DIV-1:0]    pulse_v;
   logic [CNT_W-1:0]    div_v [N_DIV];

   clksyn_setup_decode #(
      .TRIM_W(TRIM_W), .RANGE_RST(RANGE_RST[TRIM_W-1:0]),
      .OFFSET_RST(OFFSET_RST[TRIM_W-1:0]), .CODE_RST(CODE_RST), .EN_RST(EN_RST)
   ) i_decode (
      .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid),
      .msg_a(msg_a), .msg_b(msg_b), .msg_c(msg_c),
      .osc_en(osc_en), .ratio_code(ratio_code), .range_trim(range_trim),
      .offset_trim(offset_trim), .lock_ctl(lock_ctl), .disc_ctl(disc_ctl),
      .ratio_load(ratio_load)
   );

   assign div_clr  = !osc_en || ratio_load;
   assign tick_v   = {fb_tick, ref_tick};
   assign div_v[0] = CNT_W'(ref_div(ratio_code));
   assign div_v[1] = CNT_W'(fb_div(ratio_code));

   for (genvar g = 0; g < N_DIV; g++) begin : g_div
      clksyn_tick_div #(.CNT_W(CNT_W)) i_div (
         .clk(clk), .rst_n(rst_n), .clr(div_clr), .tick(tick_v[g]),
         .div_n(div_v[g]), .pulse(pulse_v[g])
      );
   end

   assign ref_pulse = pulse_v[0];
   assign fb_pulse  = pulse_v[1];

   p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_en && !$past(osc_en)) |-> (!ref_pulse && !fb_pulse));

   p_sleep_no_effect_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ((sleep_req != $past(sleep_req)) && !msg_valid) |=> $stable(osc_en));
endmodule

// File: tb/test_clksyn_setup_ctrl.sv
module test_clksyn_setup_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       msg_valid = 1'b0;
   logic [7:0] msg_a = '0, msg_b = '0, msg_c = '0;
   logic       sleep_req = 1'b0;
   logic       ticks = 1'b0;
   logic       tick_mode = 1'b0;
   logic       osc_en, lock_ctl, ref_pulse, fb_pulse;
   logic [2:0] ratio_code;
   logic [5:0] range_trim, offset_trim;
   logic [1:0] disc_ctl;
   int total = 0, bad = 0;

   always #5 clk = ~clk;

   clksyn_setup_ctrl i_clksyn_setup_ctrl (
      .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_a(msg_a), .msg_b(msg_b),
      .msg_c(msg_c), .sleep_req(sleep_req), .ref_tick(ticks), .fb_tick(ticks),
      .osc_en(osc_en), .ratio_code(ratio_code), .range_trim(range_trim),
      .offset_trim(offset_trim), .lock_ctl(lock_ctl), .disc_ctl(disc_ctl),
      .ref_pulse(ref_pulse), .fb_pulse(fb_pulse)
   );

   // fields: req[46:43] a[42:35] b[34:27] c[26:19] en[18] code[17:15] range[14:9] off[8:3] lock[2] disc[1:0]
   localparam int NV = 11;
   localparam logic [46:0] VEC [NV] = '{
      {4'd3,  8'h3F, 8'h90, 8'h00, 1'b1, 3'd6, 6'h3F, 6'h0A, 1'b0, 2'd0}, // R3 range load
      {4'd4,  8'h15, 8'h88, 8'h00, 1'b1, 3'd6, 6'h3F, 6'h15, 1'b0, 2'd0}, // R4 offset load
      {4'd2,  8'h00, 8'h80, 8'h00, 1'b0, 3'd6, 6'h3F, 6'h15, 1'b0, 2'd0}, // R2 off
      {4'd2,  8'h00, 8'h81, 8'h00, 1'b1, 3'd6, 6'h3F, 6'h15, 1'b0, 2'd0}, // R2 on
      {4'd1,  8'h00, 8'h50, 8'h00, 1'b1, 3'd6, 6'h3F, 6'h15, 1'b0, 2'd0}, // R1 bad header
      {4'd1,  8'h00, 8'h90, 8'h01, 1'b1, 3'd6, 6'h3F, 6'h15, 1'b0, 2'd0}, // R1 bad trailer
      {4'd6,  8'hA3, 8'h80, 8'h20, 1'b1, 3'd3, 6'h3F, 6'h15, 1'b1, 2'd2}, // R6 ratio fields
      {4'd9,  8'h07, 8'h80, 8'h20, 1'b1, 3'd3, 6'h3F, 6'h15, 1'b1, 2'd2}, // R9 unlisted code
      {4'd7,  8'h24, 8'h98, 8'h20, 1'b1, 3'd4, 6'h3F, 6'h15, 1'b1, 2'd0}, // R7 ratio first
      {4'd7,  8'h05, 8'h98, 8'h00, 1'b1, 3'd4, 6'h05, 6'h15, 1'b1, 2'd0}, // R7 range over offset
      {4'd4,  8'h0C, 8'h88, 8'h00, 1'b1, 3'd4, 6'h05, 6'h0C, 1'b1, 2'd0}  // R4 offset again
   };

   initial begin
      forever begin
         @(negedge clk);
         ticks = tick_mode ? ~ticks : 1'b1;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic chk(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
      @(negedge clk);
      msg_a = a; msg_b = b; msg_c = c; msg_valid = 1'b1;
      @(negedge clk);
      msg_valid = 1'b0;
   endtask

   task automatic period(input bit use_fb, output int p);
      int guard;
      p = -1;
      guard = 0;
      while (((use_fb ? fb_pulse : ref_pulse) !== 1'b1) && guard < 5000) begin
         @(negedge clk); guard++;
      end
      guard = 0;
      do begin
         @(negedge clk); guard++;
      end while (((use_fb ? fb_pulse : ref_pulse) !== 1'b1) && guard < 5000);
      p = guard;
   endtask

   function automatic logic [18:0] state();
      return {osc_en, ratio_code, range_trim, offset_trim, lock_ctl, disc_ctl};
   endfunction

   initial begin
      int p;
      int c_ref, c_fb, cnt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R5 reset state", state(), {1'b1, 3'd6, 6'h21, 6'h0A, 1'b0, 2'd0});

      for (int i = 0; i < NV; i++) begin
         send(VEC[i][42:35], VEC[i][34:27], VEC[i][26:19]);
         chk($sformatf("R%0d vector %0d", VEC[i][46:43], i), state(), VEC[i][18:0]);
      end

      // R8 divider table, ticks every cycle
      send(8'h04, 8'h80, 8'h20);
      period(1'b0, p); chk("R8 code100 ref", p, 100);
      period(1'b1, p); chk("R8 code100 fb", p, 63);
      send(8'h03, 8'h80, 8'h20);
      period(1'b0, p); chk("R8 code011 ref", p, 825);
      period(1'b1, p); chk("R8 code011 fb", p, 448);
      send(8'h05, 8'h80, 8'h20);
      period(1'b0, p); chk("R8 code101 ref", p, 337);
      period(1'b1, p); chk("R8 code101 fb", p, 183);
      send(8'h06, 8'h80, 8'h20);
      period(1'b0, p); chk("R8 code110 ref", p, 120);
      period(1'b1, p); chk("R8 code110 fb", p, 63);

      // R11 restart on ratio write: first pulse N+1 cycles after the strobe edge
      send(8'h06, 8'h80, 8'h20);
      c_ref = -1; c_fb = -1;
      for (int k = 1; k <= 400 && (c_ref < 0 || c_fb < 0); k++) begin
         @(negedge clk);
         if (ref_pulse && c_ref < 0) c_ref = k;
         if (fb_pulse && c_fb < 0) c_fb = k;
      end
      chk("R11 ref first pulse", c_ref, 121);
      chk("R11 fb first pulse", c_fb, 64);

      // R11 ticks on alternate cycles
      tick_mode = 1'b1;
      period(1'b0, p); period(1'b0, p); chk("R11 ref half-rate", p, 240);
      period(1'b1, p); chk("R11 fb half-rate", p, 126);
      tick_mode = 1'b0;
      repeat (4) @(negedge clk);

      // R10 disabled: no pulses
      send(8'h00, 8'h80, 8'h00);
      chk("R10 disabled", osc_en, 0);
      @(negedge clk);
      cnt = 0;
      for (int k = 0; k < 1000; k++) begin
         @(negedge clk);
         if (ref_pulse || fb_pulse) cnt++;
      end
      chk("R10 no pulses while off", cnt, 0);

      // R12 sleep does not wake it
      sleep_req = 1'b1;
      repeat (300) @(negedge clk);
      chk("R12 sleep keeps off", osc_en, 0);

      // R10 re-enable under sleep: first ref pulse on N-th tick
      send(8'h00, 8'h81, 8'h00);
      c_ref = -1;
      for (int k = 1; k <= 400 && c_ref < 0; k++) begin
         @(negedge clk);
         if (ref_pulse) c_ref = k;
      end
      chk("R10 first pulse after enable", c_ref, 120);

      // R12 leaving sleep leaves state and pulses unchanged
      sleep_req = 1'b0;
      repeat (5) @(negedge clk);
      chk("R12 wake keeps state", state(), {1'b1, 3'd6, 6'h05, 6'h0C, 1'b0, 2'd0});
      period(1'b0, p); chk("R12 ref period after wake", p, 120);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule